// File: doc/BRIEF.md
# Fractional Clock Divider with Selectable MASH Noise Shaping

This block derives a slower clock from a parent clock. The division ratio is made of an unsigned integer part `div_int` and a 12-bit fraction `div_frac`. The fraction is read as `div_frac / 4096`. A two-bit `order` input selects how the fraction is used. With order 0 the fraction is ignored and the divider is a plain counter with an exactly balanced waveform. With orders 1, 2 and 3 a cascade of three accumulators forms a MASH 1-1-1 sigma-delta modulator. The modulator advances once per output period and adds a small signed offset to the integer divisor of each new period. The long-run average ratio is then `div_int + div_frac/4096`, and the error energy is pushed to high frequencies.

Higher orders widen the per-period spread. Each order therefore needs a larger minimum integer divisor before it can be used. An illegal combination raises `cfg_err` at once and the divider falls back to integer division. New settings are sampled only at the start of an output period, so the output never shows a shortened pulse. While `en` is low the output is held low and the modulator restarts from a cleared state.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst_n` or `en` is low, `clk_out` is low, from the second parent edge after `en` is sampled low at the latest. The first parent rising edge that samples `en` high starts an output period, and `clk_out` is high just after that edge.
- R2: With `order` = 0 every output period lasts exactly `div_int` parent cycles, whatever the value of `div_frac`.
- R3: With `order` = 0 the high time of each period is exactly half the period. Odd divisors are handled by a half-cycle extension on the falling parent edge.
- R4: With `order` = 1 every period lasts `div_int` or `div_int`+1 parent cycles.
- R5: With `order` = 2 every period lasts between `div_int`-1 and `div_int`+2 parent cycles.
- R6: With `order` = 3 every period lasts between `div_int`-3 and `div_int`+4 parent cycles.
- R7: In the dithered orders the modulator starts cleared at enable. The total length of the first N periods lies between N·`div_int` + floor(N·`div_frac`/4096) − 1 and the same value + 2.
- R8: In the dithered orders the high time of each period is floor(L/2) whole parent cycles, where L is that period's length.
- R9: The smallest legal `div_int` is 2 for orders 0 and 1, 3 for order 2 and 5 for order 3. A smaller value drives `cfg_err` high combinationally. The divider then runs integer division by max(`div_int`, 2).
- R10: A change of `div_int`, `div_frac` or `order` during a period does not change that period. It applies from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the output low and clears the modulator |
| div_int | input | INT_W (8) | Integer part of the division ratio |
| div_frac | input | FRAC_W (12) | Fractional part, in units of 1/2^FRAC_W |
| order | input | 2 | 0 integer only, 1/2/3 MASH order |
| clk_out | output | 1 | Divided clock |
| cfg_err | output | 1 | Current settings are illegal for the selected order |

## Verification
A corrupted accumulator or a stale carry delay shows up as a period outside the spread window of its order. That period appears within one output period of the fault. A slow drift of the residue instead moves the summed length of a long run of periods away from the arithmetic target, so the bench sweeps orders, divisors and fractions over runs of 128 periods. A counter or duty fault changes the period length or the high time of the very next period. An early capture of the settings shortens the period that is running when the settings change.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
package fdiv_pkg;

   typedef enum logic [1:0] {
      MODE_INT = 2'd0,
      MODE_O1  = 2'd1,
      MODE_O2  = 2'd2,
      MODE_O3  = 2'd3
   } fdiv_mode_e;

   // number of accumulators in the MASH 1-1-1 cascade
   localparam int MASH_STAGES = 3;

   // smallest integer divisor that keeps every dithered period at 2 or more
   function automatic logic [3:0] min_divisor(input fdiv_mode_e m);
      logic [3:0] r;
      unique case (m)
         MODE_INT: r = 4'd2;
         MODE_O1:  r = 4'd2;
         MODE_O2:  r = 4'd3;
         default:  r = 4'd5;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/fdiv_legal.sv
`timescale 1ns/1ps
module fdiv_legal
   import fdiv_pkg::*;
#(
   parameter int INT_W = 8
) (
   input  logic [INT_W-1:0] div_int,
   input  fdiv_mode_e       mode_req,
   output logic             err,
   output fdiv_mode_e       mode_eff,
   output logic [INT_W-1:0] int_eff
);

   logic [INT_W-1:0] limit;
   logic             too_small;

   always_comb begin
      limit     = INT_W'(min_divisor(mode_req));
      too_small = (div_int < INT_W'(2));
      err       = (div_int < limit);
      mode_eff  = err ? MODE_INT : mode_req;
      int_eff   = too_small ? INT_W'(2) : div_int;
   end

endmodule

// File: rtl/fdiv_mash.sv
`timescale 1ns/1ps
module fdiv_mash
   import fdiv_pkg::*;
#(
   parameter int FRAC_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic [FRAC_W-1:0] frac,
   input  fdiv_mode_e        order,
   output logic signed [3:0] dsig
);

   localparam int NST = MASH_STAGES;

   logic [NST-1:0][FRAC_W-1:0] stage_in;
   logic [NST-1:0][FRAC_W-1:0] residue;
   logic [NST-1:0]             cy;
   logic [NST-1:0]             active;

   assign stage_in[0] = frac;

   for (genvar k = 0; k < NST; k++) begin : g_stage
      logic [FRAC_W-1:0] acc_q;
      logic [FRAC_W:0]   sum;

      assign active[k]  = (int'(order) > k);
      assign sum        = {1'b0, acc_q} + {1'b0, stage_in[k]};
      assign residue[k] = sum[FRAC_W-1:0];
      assign cy[k]      = active[k] & sum[FRAC_W];

      if (k + 1 < NST) begin : g_link
         assign stage_in[k+1] = sum[FRAC_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q <= '0;
         end else if (clr || !active[k]) begin
            acc_q <= '0;
         end else if (step) begin
            acc_q <= residue[k];
         end
      end
   end

   // carry history for the difference stages
   logic c2_d, c3_d, c3_dd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c2_d  <= 1'b0;
         c3_d  <= 1'b0;
         c3_dd <= 1'b0;
      end else if (clr) begin
         c2_d  <= 1'b0;
         c3_d  <= 1'b0;
         c3_dd <= 1'b0;
      end else begin
         if (!active[1]) begin
            c2_d <= 1'b0;
         end else if (step) begin
            c2_d <= cy[1];
         end
         if (!active[2]) begin
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
         end else if (step) begin
            c3_d  <= cy[2];
            c3_dd <= c3_d;
         end
      end
   end

   logic signed [3:0] t1, t2, t3;

   always_comb begin
      t1 = $signed({3'b000, cy[0]});
      t2 = active[1] ? ($signed({3'b000, cy[1]}) - $signed({3'b000, c2_d})) : 4'sd0;
      t3 = active[2] ? ($signed({3'b000, cy[2]}) - $signed({2'b00, c3_d, 1'b0})
                        + $signed({3'b000, c3_dd})) : 4'sd0;
      dsig = t1 + t2 + t3;
   end

   // R2: integer mode never offsets the divisor
   a_r2_no_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (order == MODE_INT) |-> (dsig == 4'sd0));

   // R6: widest spread of the cascade
   a_r6_dsig_range: assert property (@(posedge clk) disable iff (!rst_n)
      (dsig >= -4'sd3) && (dsig <= 4'sd4));

endmodule

// File: rtl/fdiv_period.sv
`timescale 1ns/1ps
module fdiv_period
   import fdiv_pkg::*;
#(
   parameter int INT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [INT_W-1:0]  int_eff,
   input  fdiv_mode_e        mode_eff,
   input  logic signed [3:0] dsig,
   output logic              step,
   output logic              clk_out
);

   localparam int LEN_W = INT_W + 1;

   logic                    running;
   logic [LEN_W-1:0]        cnt;
   logic [LEN_W-1:0]        len_q;
   logic [LEN_W-1:0]        hi_q;
   logic                    odd_int_q;
   logic                    half_q;
   logic                    load;
   logic signed [LEN_W:0]   len_calc;
   logic [LEN_W-1:0]        new_len;

   always_comb begin
      len_calc = $signed({2'b00, int_eff}) + {{(LEN_W-3){dsig[3]}}, dsig};
      new_len  = len_calc[LEN_W-1:0];
      load     = en && (!running || (cnt == len_q - 1'b1));
   end

   assign step = load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running   <= 1'b0;
         cnt       <= '0;
         len_q     <= '0;
         hi_q      <= '0;
         odd_int_q <= 1'b0;
      end else if (!en) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (load) begin
         running   <= 1'b1;
         cnt       <= '0;
         len_q     <= new_len;
         hi_q      <= new_len >> 1;
         odd_int_q <= (mode_eff == MODE_INT) && new_len[0];
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // half-cycle extension of the high phase for odd integer divisors
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= 1'b0;
      end else begin
         half_q <= running && odd_int_q && (cnt == hi_q - 1'b1);
      end
   end

   assign clk_out = (running && (cnt < hi_q)) || half_q;

   // R1: disabled output is low one edge later
   a_r1_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !clk_out);

   // R4: first order spread
   a_r4_o1_spread: assert property (@(posedge clk) disable iff (!rst_n)
      (load && mode_eff == MODE_O1) |-> (dsig == 4'sd0 || dsig == 4'sd1));

   // R5: second order spread
   a_r5_o2_spread: assert property (@(posedge clk) disable iff (!rst_n)
      (load && mode_eff == MODE_O2) |-> (dsig >= -4'sd1 && dsig <= 4'sd2));

   // R9: the legality guard keeps every period at two cycles or more
   a_r9_min_len: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (new_len >= LEN_W'(2)));

   // R10: period length only changes at a boundary
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en && running && !load) |=> (len_q == $past(len_q)));

endmodule

// File: rtl/frac_clk_div.sv
`timescale 1ns/1ps
module frac_clk_div
   import fdiv_pkg::*;
#(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   input  logic [1:0]        order,
   output logic              clk_out,
   output logic              cfg_err
);

   if (INT_W < 4 || INT_W > 16) begin : g_bad_int
      $error("frac_clk_div: INT_W must be in 4..16");
   end
   if (FRAC_W < 4 || FRAC_W > 24) begin : g_bad_frac
      $error("frac_clk_div: FRAC_W must be in 4..24");
   end

   fdiv_mode_e        mode_eff;
   logic [INT_W-1:0]  int_eff;
   logic signed [3:0] dsig;
   logic              step;

   fdiv_legal #(.INT_W(INT_W)) u_legal (
      .div_int  (div_int),
      .mode_req (fdiv_mode_e'(order)),
      .err      (cfg_err),
      .mode_eff (mode_eff),
      .int_eff  (int_eff)
   );

   fdiv_mash #(.FRAC_W(FRAC_W)) u_mash (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!en),
      .step  (step),
      .frac  (div_frac),
      .order (mode_eff),
      .dsig  (dsig)
   );

   fdiv_period #(.INT_W(INT_W)) u_period (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .int_eff  (int_eff),
      .mode_eff (mode_eff),
      .dsig     (dsig),
      .step     (step),
      .clk_out  (clk_out)
   );

endmodule

// File: tb/frac_clk_div_test.sv
`timescale 1ns/1ps
module frac_clk_div_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [7:0]  div_int = 8'd4;
   logic [11:0] div_frac = 12'd0;
   logic [1:0]  order = 2'd0;
   logic        clk_out;
   logic        cfg_err;

   int ncheck = 0;
   int nbad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   frac_clk_div uut (
      .clk(clk), .rst_n(rst_n), .en(en), .div_int(div_int),
      .div_frac(div_frac), .order(order), .clk_out(clk_out), .cfg_err(cfg_err)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         nbad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("  test done: total=%0d bad=%0d", ncheck, nbad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      ncheck++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(output logic s);
      @(posedge clk);
      #1;
      s = clk_out;
   endtask

   task automatic wait_rise();
      logic p, s;
      p = 1'b1;
      forever begin
         tick(s);
         if (!p && s) break;
         p = s;
      end
   endtask

   // call right after a rise; measures n whole periods
   task automatic run_periods(input int n, output int mn, output int mx,
                              output int sum, output int hi_bad);
      logic p, s;
      int len, hi, got;
      mn = 1 << 20; mx = 0; sum = 0; hi_bad = 0;
      len = 1; hi = 1; got = 0; p = 1'b1;
      while (got < n) begin
         tick(s);
         if (!p && s) begin
            if (len < mn) mn = len;
            if (len > mx) mx = len;
            sum += len;
            if (hi != len / 2) hi_bad++;
            got++;
            len = 1; hi = 1;
         end else begin
            len++;
            if (s) hi++;
         end
         p = s;
      end
   endtask

   task automatic restart(input int i, input int f, input int m);
      logic s;
      en = 1'b0;
      repeat (3) tick(s);
      div_int = 8'(i); div_frac = 12'(f); order = 2'(m);
      tick(s);
      en = 1'b1;
      wait_rise();
   endtask

   function automatic int min_div(input int m);
      return (m == 3) ? 5 : (m == 2) ? 3 : 2;
   endfunction

   initial begin
      logic s;
      int mn, mx, sum, hb;
      int lo_off[4] = '{0, 0, -1, -3};
      int hi_off[4] = '{0, 1, 2, 4};
      int fr[4] = '{1, 'h555, 'h800, 'hFFF};
      realtime t0, t1, t2;

      // R1 reset state
      #5;
      chk(clk_out == 1'b0, "R1 reset low", clk_out, 0);
      chk(cfg_err == 1'b0, "R9 legal at reset", cfg_err, 0);
      #10 rst_n = 1'b1;
      for (int k = 0; k < 10; k++) begin
         tick(s);
         chk(s == 1'b0, "R1 disabled low", s, 0);
      end

      // R1 enable starts a period on the first edge
      en = 1'b1;
      tick(s);
      chk(s == 1'b1, "R1 first edge high", s, 1);

      // R2 integer sweep, fraction ignored
      for (int i = 2; i <= 12; i++) begin
         restart(i, 'hABC, 0);
         run_periods(8, mn, mx, sum, hb);
         chk(mn == i && mx == i, "R2 integer period", mx, i);
      end

      // R3 exact half duty in integer mode
      foreach (fr[j]) begin
         int i;
         i = 2 + 2 * j + (j % 2);
         restart(i, 'h7FF, 0);
         @(posedge clk_out); t0 = $realtime;
         @(negedge clk_out); t1 = $realtime;
         @(posedge clk_out); t2 = $realtime;
         chk(int'((t2 - t0) * 1000) == i * 4000, "R3 period time", int'((t2 - t0) * 1000), i * 4000);
         chk(int'((t1 - t0) * 1000) == i * 2000, "R3 high time", int'((t1 - t0) * 1000), i * 2000);
      end

      // R4 R5 R6 R7 R8 dithered sweeps
      for (int m = 1; m <= 3; m++) begin
         int ilist[3];
         ilist = '{min_div(m), 6, 9};
         foreach (ilist[a]) begin
            foreach (fr[b]) begin
               int i, base;
               i = ilist[a];
               restart(i, fr[b], m);
               run_periods(128, mn, mx, sum, hb);
               base = 128 * i + (128 * fr[b]) / 4096;
               if (m == 1) begin
                  chk(mn >= i && mx <= i + 1, "R4 order1 spread", mx, i + 1);
               end else if (m == 2) begin
                  chk(mn >= i - 1 && mx <= i + 2, "R5 order2 spread", mx, i + 2);
               end else begin
                  chk(mn >= i + lo_off[3] && mx <= i + hi_off[3], "R6 order3 spread", mn, i - 3);
               end
               chk(sum >= base - 1 && sum <= base + 2, "R7 average ratio", sum, base);
               chk(hb == 0, "R8 dithered high time", hb, 0);
            end
         end
      end

      // R7 ratio 3.125 in order 2
      restart(3, 512, 2);
      run_periods(256, mn, mx, sum, hb);
      chk(sum >= 256 * 3 + 32 - 1 && sum <= 256 * 3 + 32 + 2, "R7 ratio 3.125", sum, 800);
      chk(mn >= 3 + lo_off[2] && mx <= 3 + hi_off[2], "R5 ratio 3.125 spread", mx, 5);

      // R9 legality table
      en = 1'b0;
      for (int m = 0; m < 4; m++) begin
         for (int i = 0; i < 8; i++) begin
            div_int = 8'(i); order = 2'(m);
            #1;
            chk(cfg_err == (i < min_div(m)), "R9 error flag", cfg_err, int'(i < min_div(m)));
         end
      end

      // R9 fallback to integer division
      restart(3, 'h400, 3);
      run_periods(16, mn, mx, sum, hb);
      chk(cfg_err == 1'b1, "R9 order3 div3 flagged", cfg_err, 1);
      chk(mn == 3 && mx == 3, "R9 fallback div3", mx, 3);
      restart(4, 'h100, 3);
      run_periods(16, mn, mx, sum, hb);
      chk(mn == 4 && mx == 4, "R9 fallback div4", mx, 4);
      restart(1, 0, 0);
      run_periods(8, mn, mx, sum, hb);
      chk(mn == 2 && mx == 2, "R9 divisor 1 runs as 2", mx, 2);

      // R10 change mid period
      restart(6, 0, 0);
      div_int = 8'd10;
      run_periods(1, mn, mx, sum, hb);
      chk(sum == 6, "R10 running period kept", sum, 6);
      run_periods(1, mn, mx, sum, hb);
      chk(sum == 10, "R10 new period applied", sum, 10);
      order = 2'd1; div_frac = 12'h800;
      run_periods(1, mn, mx, sum, hb);
      chk(sum == 10, "R10 mode change waits", sum, 10);

      // R1 disable mid run
      restart(5, 0, 0);
      en = 1'b0;
      tick(s);
      for (int k = 0; k < 12; k++) begin
         tick(s);
         chk(s == 1'b0, "R1 low after disable", s, 0);
      end

      $display("  test done: total=%0d bad=%0d", ncheck, nbad);
      $finish;
   end

endmodule